// File: doc/BRIEF.md
# PWM Compare Timer

This block is a single-channel timer that produces a pulse-width-modulated pin level. A clock divider feeds a counter that runs either upward (wrapping from the auto-reload limit back to zero) or downward (reloading the limit after zero). One compare value, held behind an optional shadow register, is tested against the counter. One of two complementary PWM modes turns that comparison into the pin level. Every period boundary raises a one-cycle update pulse.

Software sets the block up through a write-only register port: a control word, a self-clearing event bit, the divider value, the reload limit, the compare value and a direct counter load. The event bit forces an update at once. The counter is reinitialised, the divider is cleared and a pending shadow compare value becomes active, all in the same cycle. The pin is always driven. It is low when the output is disabled or an unused mode code is selected. A compare value of zero gives a true 0% duty. A compare value above the limit gives a true 100% duty, with no edge at the wrap.

Top module: `pwm_timer`

## Requirements
- R1: Reset (rst_n low at a clock edge) clears every register to 0 and stops the counter. pwm_out and upd_pulse are 0 and stay 0 until the block is written.
- R2: The divider (write address 2) makes the counter step once every PSC+1 clocks. One output period therefore lasts (PSC+1)*(ARR+1) clocks.
- R3: With the control word's direction bit (bit 1) at 0, the counter counts up and goes from ARR (write address 3) to 0. Each such wrap gives one upd_pulse, one clock wide, one clock after the wrap edge.
- R4: With the direction bit at 1, the counter counts down and reloads ARR after reaching 0. Each reload gives one upd_pulse.
- R5: Mode code 3'b110 in control bits [6:4] drives the pin high while CNT < CCR when counting up. When counting down it drives the pin low while CNT > CCR and high otherwise (CCR is write address 4).
- R6: Mode code 3'b111 drives the pin to the exact complement of the level that code 3'b110 would give for the same counter and compare value.
- R7: Under code 3'b110, CCR = 0 holds the pin constantly low in both directions. CCR >= ARR+1 holds it constantly high with no edge at the period boundary.
- R8: With the preload bit (control bit 3) at 1, a CCR write goes to a shadow register, and the compare value in use changes only at an update event. With the preload bit at 0, a CCR write takes effect immediately.
- R9: Writing 1 to bit 0 at write address 1 raises an update event even while the counter is stopped. The event sets the counter to 0 when counting up and to ARR when counting down, clears the divider and gives one upd_pulse. The bit holds no state.
- R10: With the output-enable bit (control bit 2) at 0, or with any mode code other than 3'b110 and 3'b111, the pin is driven low.
- R11: With the run bit (control bit 0) at 0, the counter holds its value and no update pulses occur. A write to address 5 loads the counter directly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address (0 control, 1 event, 2 divider, 3 limit, 4 compare, 5 counter) |
| wr_data | input | DATA_W (16) | Register write data |
| pwm_out | output | 1 | PWM pin level, always driven |
| upd_pulse | output | 1 | One-clock pulse per update event |

## Verification
The bench counts high clocks over whole periods with the compare value at 0, at half the limit, at the limit and at the limit plus one, in both modes and both directions. A design that left a one-clock spike at the wrap, or an off-by-one in the down-count compare, would miss those totals by a few clocks. With the counter stopped, the bench uses direct counter loads as a probe of the counter's state. This shows whether the event bit reinitialises the counter toward the correct end for each direction and whether a preloaded compare value leaks through before the event. It also forces a disabled output and an unused mode code with a full-duty compare value, where a design that let the comparison reach the pin would read high.

// File: rtl/pwm_timer_pkg.sv
// Shared definitions for the PWM compare timer: write addresses,
// mode codes and the layout of the control word.
package pwm_timer_pkg;

    typedef enum logic [2:0] {
        REG_CTRL  = 3'd0,
        REG_EVENT = 3'd1,
        REG_PSC   = 3'd2,
        REG_ARR   = 3'd3,
        REG_CCR   = 3'd4,
        REG_CNT   = 3'd5
    } reg_addr_e;

    localparam logic [2:0] MODE_PWM_A = 3'b110;
    localparam logic [2:0] MODE_PWM_B = 3'b111;

    localparam int CTRL_W = 7;

    // Bit layout, MSB first: mode[6:4], preload[3], out_en[2], down[1], run[0]
    typedef struct packed {
        logic [2:0] mode;
        logic       preload;
        logic       out_en;
        logic       down;
        logic       run;
    } ctrl_t;

endpackage

// File: rtl/pwm_regs.sv
// Register write decoder. It holds the control word, the divider value
// and the reload limit, and turns writes to the event, compare and
// counter addresses into single-cycle strobes for the other units.
// Assumes DATA_W is at least CNT_W, PSC_W and the control word width.
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output ctrl_t             ctrl,
    output logic [PSC_W-1:0]  psc,
    output logic [CNT_W-1:0]  arr,
    output logic              ccr_wr,
    output logic [CNT_W-1:0]  ccr_wdata,
    output logic              cnt_wr,
    output logic [CNT_W-1:0]  cnt_wdata,
    output logic              ug
);

    // Store the control word, the divider and the limit on their writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            psc  <= '0;
            arr  <= '0;
        end else if (wr_en) begin
            case (wr_addr)
                REG_CTRL: ctrl <= ctrl_t'(wr_data[CTRL_W-1:0]);
                REG_PSC:  psc  <= wr_data[PSC_W-1:0];
                REG_ARR:  arr  <= wr_data[CNT_W-1:0];
                default:  ;
            endcase
        end
    end

    // Decode the strobe-type addresses; the event bit is never stored.
    always_comb begin
        ug        = wr_en && (wr_addr == REG_EVENT) && wr_data[0];
        ccr_wr    = wr_en && (wr_addr == REG_CCR);
        cnt_wr    = wr_en && (wr_addr == REG_CNT);
        ccr_wdata = wr_data[CNT_W-1:0];
        cnt_wdata = wr_data[CNT_W-1:0];
    end

endmodule

// File: rtl/pwm_prescaler.sv
// Clock divider. It emits one step strobe every psc+1 clocks while
// enabled, and restarts its phase whenever an update is forced.
// Assumes psc may change at any time; a lowered value takes effect at once.
module pwm_prescaler #(
    parameter int PSC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             clr,
    input  logic [PSC_W-1:0] psc,
    output logic             tick
);

    logic [PSC_W-1:0] div_q;

    // Step strobe when the phase has reached the divider value.
    always_comb tick = run && !clr && (div_q >= psc);

    // Advance the divider phase, wrapping on each step.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            div_q <= '0;
        end else if (run) begin
            if (div_q >= psc) div_q <= '0;
            else              div_q <= div_q + 1'b1;
        end
    end

    AST_PSC_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc != '0) |=> (!tick || psc == '0)); // R2

endmodule

// File: rtl/pwm_counter.sv
// Up/down period counter. It steps on each divider strobe, wraps at the
// reload limit (up) or at zero (down), and raises the update event on each
// wrap or forced update. Also registers the update pulse for the pin.
// Priority per clock: forced update, then direct load, then a step.
module pwm_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             down,
    input  logic [CNT_W-1:0] arr,
    input  logic             ug,
    input  logic             cnt_wr,
    input  logic [CNT_W-1:0] cnt_wdata,
    output logic [CNT_W-1:0] cnt,
    output logic             uev,
    output logic             upd_pulse
);

    logic wrap;

    // Period end: the limit when counting up, zero when counting down.
    always_comb wrap = down ? (cnt == '0) : (cnt >= arr);

    // Update event from a wrap step or a forced update.
    always_comb uev = ug || (tick && wrap && !cnt_wr);

    // Counter register with forced-update, load and step paths.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ug) begin
            cnt <= down ? arr : '0;
        end else if (cnt_wr) begin
            cnt <= cnt_wdata;
        end else if (tick) begin
            if (wrap)      cnt <= down ? arr : '0;
            else if (down) cnt <= cnt - 1'b1;
            else           cnt <= cnt + 1'b1;
        end
    end

    // One-clock update pulse, registered for a clean output.
    always_ff @(posedge clk) begin
        if (!rst_n) upd_pulse <= 1'b0;
        else        upd_pulse <= uev;
    end

    AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !ug && !cnt_wr) |=> $stable(cnt)); // R11
    AST_UP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !down && cnt >= arr && !ug && !cnt_wr) |=> (cnt == '0 && upd_pulse)); // R3
    AST_DOWN_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && down && cnt == '0 && !ug && !cnt_wr) |=> (cnt == $past(arr) && upd_pulse)); // R4
    AST_FORCED_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
        ug |=> upd_pulse); // R9

endmodule

// File: rtl/pwm_compare.sv
// Compare and output stage. It holds the shadow and active compare
// values, derives the pin level from the counter for the selected mode
// and direction, and registers the pin. A zero compare value disables the
// active phase of the first mode entirely, so 0% is exact in both directions.
module pwm_compare
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] arr,
    input  logic             down,
    input  logic [2:0]       mode,
    input  logic             out_en,
    input  logic             preload,
    input  logic             ccr_wr,
    input  logic [CNT_W-1:0] ccr_wdata,
    input  logic             uev,
    output logic             pwm_out
);

    logic [CNT_W-1:0] ccr_shadow;
    logic [CNT_W-1:0] ccr_active;
    logic             lvl_a;
    logic             pin_next;

    // Shadow register takes every compare write.
    always_ff @(posedge clk) begin
        if (!rst_n)      ccr_shadow <= '0;
        else if (ccr_wr) ccr_shadow <= ccr_wdata;
    end

    // Active value: direct write without preload, else copied on update.
    always_ff @(posedge clk) begin
        if (!rst_n)                 ccr_active <= '0;
        else if (ccr_wr && !preload) ccr_active <= ccr_wdata;
        else if (uev)               ccr_active <= ccr_shadow;
    end

    // First-mode level: below compare when up, not above it when down.
    always_comb begin
        if (ccr_active == '0) lvl_a = 1'b0;
        else if (down)        lvl_a = (cnt <= ccr_active);
        else                  lvl_a = (cnt < ccr_active);
    end

    // Mode select and output gate; unknown codes and disabled drive low.
    always_comb begin
        if (!out_en)                 pin_next = 1'b0;
        else if (mode == MODE_PWM_A) pin_next = lvl_a;
        else if (mode == MODE_PWM_B) pin_next = !lvl_a;
        else                         pin_next = 1'b0;
    end

    // Registered pin so the level never glitches between edges.
    always_ff @(posedge clk) begin
        if (!rst_n) pwm_out <= 1'b0;
        else        pwm_out <= pin_next;
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |=> !pwm_out); // R10
    AST_ZERO_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode == MODE_PWM_A && ccr_active == '0) |=> !pwm_out); // R7
    AST_FULL_DUTY: assert property (@(posedge clk) disable iff (!rst_n)
        (out_en && mode == MODE_PWM_A && ccr_active > arr && cnt <= arr) |=> pwm_out); // R7
    AST_PRELOAD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (preload && !uev) |=> $stable(ccr_active)); // R8

endmodule

// File: rtl/pwm_timer.sv
// Top of the PWM compare timer: register decoder, divider, period
// counter and compare/output stage. Assumes a single clock domain and
// writes arriving as one-clock strobes on wr_en.
module pwm_timer
    import pwm_timer_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int PSC_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              pwm_out,
    output logic              upd_pulse
);

    ctrl_t            ctrl;
    logic [PSC_W-1:0] psc;
    logic [CNT_W-1:0] arr;
    logic             ccr_wr;
    logic [CNT_W-1:0] ccr_wdata;
    logic             cnt_wr;
    logic [CNT_W-1:0] cnt_wdata;
    logic             ug;
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic             uev;

    pwm_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .PSC_W(PSC_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .ctrl(ctrl), .psc(psc), .arr(arr),
        .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata), .cnt_wr(cnt_wr),
        .cnt_wdata(cnt_wdata), .ug(ug)
    );

    pwm_prescaler #(.PSC_W(PSC_W)) u_psc (
        .clk(clk), .rst_n(rst_n), .run(ctrl.run), .clr(ug), .psc(psc),
        .tick(tick)
    );

    pwm_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(tick), .down(ctrl.down), .arr(arr),
        .ug(ug), .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .cnt(cnt),
        .uev(uev), .upd_pulse(upd_pulse)
    );

    pwm_compare #(.CNT_W(CNT_W)) u_cmp (
        .clk(clk), .rst_n(rst_n), .cnt(cnt), .arr(arr), .down(ctrl.down),
        .mode(ctrl.mode), .out_en(ctrl.out_en), .preload(ctrl.preload),
        .ccr_wr(ccr_wr), .ccr_wdata(ccr_wdata), .uev(uev), .pwm_out(pwm_out)
    );

endmodule

// File: tb/tb_pwm_timer.sv
module tb_pwm_timer;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = 3'd0;
    logic [15:0] wr_data = 16'd0;
    logic        pwm_out;
    logic        upd_pulse;

    int total = 0;
    int bad = 0;
    int hi_acc = 0;
    int up_acc = 0;

    pwm_timer dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out), .upd_pulse(upd_pulse)
    );

    always #10 clk = ~clk;

    // Running tallies sampled away from the active edge.
    always @(negedge clk) begin
        hi_acc <= hi_acc + int'(pwm_out);
        up_acc <= up_acc + int'(upd_pulse);
    end

    typedef struct packed {
        logic        dn;
        logic [2:0]  md;
        logic [15:0] ccr;
        logic [7:0]  hi;
    } vec_t;

    // ARR = 7, PSC = 0, 32-clock window = 4 periods; hi = expected high clocks.
    localparam vec_t VECS [16] = '{
        '{1'b0, 3'b110, 16'd0, 8'd0},  '{1'b0, 3'b110, 16'd3, 8'd12},
        '{1'b0, 3'b110, 16'd7, 8'd28}, '{1'b0, 3'b110, 16'd8, 8'd32},
        '{1'b1, 3'b110, 16'd0, 8'd0},  '{1'b1, 3'b110, 16'd3, 8'd16},
        '{1'b1, 3'b110, 16'd7, 8'd32}, '{1'b1, 3'b110, 16'd8, 8'd32},
        '{1'b0, 3'b111, 16'd0, 8'd32}, '{1'b0, 3'b111, 16'd3, 8'd20},
        '{1'b0, 3'b111, 16'd7, 8'd4},  '{1'b0, 3'b111, 16'd8, 8'd0},
        '{1'b1, 3'b111, 16'd0, 8'd32}, '{1'b1, 3'b111, 16'd3, 8'd16},
        '{1'b1, 3'b111, 16'd7, 8'd0},  '{1'b1, 3'b111, 16'd8, 8'd0}
    };

    task automatic check(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Configure, settle, then count high clocks and pulses over a window.
    task automatic run_cfg(input logic dn, input logic [2:0] md,
                           input logic [15:0] ccr, input logic [15:0] psc,
                           input int win, output int hi, output int ups);
        int h0, u0;
        wr(3'd0, 16'd0);
        wr(3'd3, 16'd7);
        wr(3'd2, psc);
        wr(3'd4, ccr);
        wr(3'd1, 16'd1);
        wr(3'd0, {9'd0, md, 1'b0, 1'b1, dn, 1'b1});
        idle(20);
        h0 = hi_acc; u0 = up_acc;
        idle(win);
        hi = hi_acc - h0; ups = up_acc - u0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int hi, ups, h0, u0;
        // R1: reset state and no activity before any write
        idle(4);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 pwm_out after reset", int'(pwm_out), 0);
        check("R1 upd_pulse after reset", int'(upd_pulse), 0);
        h0 = hi_acc; u0 = up_acc;
        idle(40);
        check("R1 no pulses while stopped", up_acc - u0, 0);
        check("R1 pin stays low", hi_acc - h0, 0);

        // R5 R6 R7 table walk, plus R3/R4 pulse counts
        foreach (VECS[i]) begin
            string tag;
            run_cfg(VECS[i].dn, VECS[i].md, VECS[i].ccr, 16'd0, 32, hi, ups);
            if (VECS[i].md == 3'b111) tag = "R6";
            else if (VECS[i].ccr == 16'd0 || VECS[i].ccr == 16'd8) tag = "R7";
            else tag = "R5";
            check($sformatf("%s vec%0d dir=%0d ccr=%0d high", tag, i, VECS[i].dn, VECS[i].ccr),
                  hi, int'(VECS[i].hi));
            check($sformatf("%s vec%0d update pulses", VECS[i].dn ? "R4" : "R3", i), ups, 4);
        end

        // R2: divider by 3 stretches the period to 24 clocks
        run_cfg(1'b0, 3'b110, 16'd3, 16'd2, 48, hi, ups);
        check("R2 high clocks with divider", hi, 18);
        check("R2 pulses with divider", ups, 2);

        // R10: output disabled with full-duty compare
        run_cfg(1'b0, 3'b110, 16'd8, 16'd0, 8, hi, ups);
        wr(3'd0, 16'h0061);
        idle(4);
        h0 = hi_acc; idle(32);
        check("R10 output disabled stays low", hi_acc - h0, 0);
        // R10: unused mode code with output enabled
        wr(3'd0, 16'h0005);
        idle(4);
        h0 = hi_acc; idle(32);
        check("R10 unused mode stays low", hi_acc - h0, 0);

        // R11: stopped counter holds and direct loads move it
        wr(3'd0, 16'h0064);
        wr(3'd3, 16'd7);
        wr(3'd4, 16'd4);
        wr(3'd5, 16'd2);
        idle(2);
        check("R11 load 2 below compare", int'(pwm_out), 1);
        wr(3'd5, 16'd6);
        idle(2);
        check("R11 load 6 above compare", int'(pwm_out), 0);
        h0 = hi_acc; u0 = up_acc;
        idle(32);
        check("R11 held level while stopped", hi_acc - h0, 0);
        check("R11 no pulses while stopped", up_acc - u0, 0);

        // R9: forced update while stopped, counting up goes to 0
        wr(3'd4, 16'd1);
        wr(3'd5, 16'd5);
        idle(2);
        check("R9 before update up", int'(pwm_out), 0);
        u0 = up_acc;
        wr(3'd1, 16'd1);
        idle(3);
        check("R9 up reinit to zero", int'(pwm_out), 1);
        check("R9 one pulse from forced update", up_acc - u0, 1);
        // R9: counting down reinitialises to the limit
        wr(3'd0, 16'h0066);
        wr(3'd4, 16'd6);
        wr(3'd5, 16'd2);
        idle(2);
        check("R9 before update down", int'(pwm_out), 1);
        wr(3'd1, 16'd1);
        idle(3);
        check("R9 down reinit to limit", int'(pwm_out), 0);

        // R8: preload holds the new compare until an update event
        wr(3'd0, 16'h0064);
        wr(3'd4, 16'd3);
        wr(3'd5, 16'd5);
        idle(2);
        check("R8 immediate write without preload", int'(pwm_out), 0);
        wr(3'd0, 16'h006C);
        wr(3'd4, 16'd8);
        idle(3);
        check("R8 shadow not yet active", int'(pwm_out), 0);
        wr(3'd1, 16'd1);
        wr(3'd5, 16'd5);
        idle(2);
        check("R8 shadow active after update", int'(pwm_out), 1);

        // R1: reset while running returns everything to idle
        run_cfg(1'b0, 3'b110, 16'd8, 16'd0, 4, hi, ups);
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        rst_n = 1'b1;
        @(negedge clk);
        h0 = hi_acc; u0 = up_acc;
        idle(32);
        check("R1 pin low after mid-run reset", hi_acc - h0, 0);
        check("R1 counter stopped after mid-run reset", up_acc - u0, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule